// File: doc/BRIEF.md
# QAM Hard-Decision Demapper

The block turns equalised complex subcarrier values into hard-decision bit groups. Each input symbol carries its own constellation select: BPSK, QPSK, 16-QAM or 64-QAM. The block therefore follows a stream in which the modulation changes from one symbol to the next with no gap. Each output word has a count field that gives how many of its low bits hold data.

Both axes go through the same datapath. The value is clamped to the constellation border, and an offset is added so the result is non-negative. A mode-dependent scale factor multiplies it, and the upper bits of the product form a level index. The index selects a Gray code pattern. BPSK and QPSK use this same path with two levels per axis, so no mode has a separate slicer. The pipeline has three register stages and accepts one symbol every cycle.

Top module: `qam_demap`

## Requirements
- R1: `in_mode` selects the constellation: 0 is BPSK, 1 is QPSK, 2 is 16-QAM and 3 is 64-QAM. With a valid output, `out_count` is 1, 2, 4 or 6 for these modes.
- R2: In BPSK, `out_bits[0]` is 1 when `in_re` >= 0 and 0 otherwise. `in_im` has no effect on the output.
- R3: In QPSK, `out_bits[1]` is 1 when `in_re` >= 0, and `out_bits[0]` is 1 when `in_im` >= 0.
- R4: For 16-QAM (L=4) and 64-QAM (L=8), each signed 16-bit axis value x is first clamped to [-16384, 16383]. The level index is then floor((x + 16384) * L / 32768), which lies in 0..L-1. Values beyond the border take the outermost level.
- R5: The bit pattern of an axis is the Gray code of its level index, i XOR (i >> 1). Adjacent levels therefore differ in exactly one bit.
- R6: In 16-QAM, the real-axis bits go to `out_bits[3:2]` and the imaginary-axis bits to `out_bits[1:0]`. In 64-QAM, the real-axis bits go to `out_bits[5:3]` and the imaginary-axis bits to `out_bits[2:0]`. Every bit at or above `out_count` is zero.
- R7: `out_valid` equals `in_valid` from three clock edges earlier. A symbol is accepted on every cycle, and idle cycles pass through as gaps.
- R8: During reset, and in every cycle where `out_valid` is low, `out_bits` and `out_count` are zero.
- R9: The mode applies only to the symbol it accompanies. When the mode changes on every cycle, each result still follows its own symbol's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol qualifier |
| in_mode | input | 2 | Constellation select for this symbol |
| in_re | input | 16 | Signed real part |
| in_im | input | 16 | Signed imaginary part |
| out_valid | output | 1 | Output word qualifier |
| out_bits | output | 6 | Hard-decision bits, LSB-aligned |
| out_count | output | 3 | Number of valid bits in `out_bits` |

## Verification
The hardest case to reach is the exact edge between two decision regions on the clamped grid. A shifted threshold or a wrong saturation value changes only a handful of the 65536 codes. The stimulus therefore sweeps every 16-bit real value in 64-QAM, with an unrelated imaginary sequence, and covers the other modes with a stride of four. Both border saturation and every threshold are crossed. A final phase changes the mode and the data from a pseudo-random sequence on each cycle, with input bubbles, so that a mode that leaks between pipeline stages shows up.

// File: rtl/qam_demap.sv
module qam_demap #(
  parameter int DW   = 16,
  parameter int HALF = 1 << (DW - 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_mode,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic [5:0]           out_bits,
  output logic [2:0]           out_count
);
  localparam int HW = $clog2(HALF);

  function automatic logic [HW:0] clamp_off(input logic signed [DW-1:0] x);
    int xi;
    xi = int'(x);
    if (xi < -HALF) xi = -HALF;
    else if (xi > HALF - 1) xi = HALF - 1;
    xi = xi + HALF;
    return xi[HW:0];
  endfunction

  function automatic logic [2:0] level_idx(input logic [HW:0] v, input logic [1:0] m);
    int k, p;
    k = (m == 2'd3) ? 8 : (m == 2'd2) ? 4 : 2;
    p = (int'(v) * k) >>> (HW + 1);
    return p[2:0];
  endfunction

  function automatic logic [2:0] gray_of(input logic [2:0] i);
    return i ^ (i >> 1);
  endfunction

  logic          v1, v2;
  logic [1:0]    m1, m2;
  logic [HW:0]   c_re, c_im;
  logic [2:0]    i_re, i_im;
  logic [2:0]    g_re, g_im;
  logic [5:0]    bits_n;
  logic [2:0]    cnt_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; m1 <= '0; c_re <= '0; c_im <= '0;
    end else begin
      v1   <= in_valid;
      m1   <= in_mode;
      c_re <= clamp_off(in_re);
      c_im <= clamp_off(in_im);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; m2 <= '0; i_re <= '0; i_im <= '0;
    end else begin
      v2   <= v1;
      m2   <= m1;
      i_re <= level_idx(c_re, m1);
      i_im <= level_idx(c_im, m1);
    end
  end

  assign g_re = gray_of(i_re);
  assign g_im = gray_of(i_im);

  always_comb begin
    case (m2)
      2'd0:    begin bits_n = {5'b0, g_re[0]};                 cnt_n = 3'd1; end
      2'd1:    begin bits_n = {4'b0, g_re[0], g_im[0]};        cnt_n = 3'd2; end
      2'd2:    begin bits_n = {2'b0, g_re[1:0], g_im[1:0]};    cnt_n = 3'd4; end
      default: begin bits_n = {g_re, g_im};                    cnt_n = 3'd6; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_bits <= '0; out_count <= '0;
    end else begin
      out_valid <= v2;
      out_bits  <= v2 ? bits_n : 6'b0;
      out_count <= v2 ? cnt_n : 3'b0;
    end
  end
endmodule

// File: rtl/qam_demap_chk.sv
module qam_demap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_mode,
  input logic       re_sign,
  input logic       out_valid,
  input logic [5:0] out_bits,
  input logic [2:0] out_count
);
  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  function automatic logic [2:0] count_for(input logic [1:0] m);
    case (m)
      2'd0: return 3'd1;
      2'd1: return 3'd2;
      2'd2: return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_count_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && out_valid) |-> (out_count == count_for($past(in_mode, 3))));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_bits == 6'd0 && out_count == 3'd0));

  assert_no_stray_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_bits >> out_count) == 6'd0));

  assert_bpsk_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && out_valid && $past(in_mode, 3) == 2'd0) |-> (out_bits[0] == !$past(re_sign, 3)));
endmodule

bind qam_demap qam_demap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .re_sign(in_re[DW-1]), .out_valid(out_valid), .out_bits(out_bits), .out_count(out_count)
);

// File: tb/tb_qam_demap.sv
module tb_qam_demap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_mode = 2'd0;
  logic signed [15:0] in_re = '0;
  logic signed [15:0] in_im = '0;
  logic out_valid;
  logic [5:0] out_bits;
  logic [2:0] out_count;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic        h_v [3];
  logic [1:0]  h_m [3];
  logic [15:0] h_re [3];
  logic [15:0] h_im [3];
  string       h_tag [3];

  always #2 clk = ~clk;

  qam_demap dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_bits(out_bits), .out_count(out_count)
  );

  function automatic int axis_code(input logic [15:0] raw, input int lv);
    int x, idx;
    x = int'($signed(raw));
    if (x < -16384) x = -16384;
    if (x > 16383) x = 16383;
    idx = (x + 16384) / (32768 / lv);
    return idx ^ (idx / 2);
  endfunction

  function automatic int exp_bits(input logic [1:0] m, input logic [15:0] re, input logic [15:0] im);
    case (m)
      2'd0: return ($signed(re) >= 0) ? 1 : 0;
      2'd1: return (($signed(re) >= 0) ? 2 : 0) + (($signed(im) >= 0) ? 1 : 0);
      2'd2: return axis_code(re, 4) * 4 + axis_code(im, 4);
      default: return axis_code(re, 8) * 8 + axis_code(im, 8);
    endcase
  endfunction

  function automatic int exp_count(input logic [1:0] m);
    case (m)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [1:0] m, input logic [15:0] re,
                       input logic [15:0] im, input string tag);
    @(negedge clk);
    check(out_valid == h_v[2], "R7 valid", int'(out_valid), int'(h_v[2]));
    if (h_v[2]) begin
      check(int'(out_count) == exp_count(h_m[2]), "R1 count", int'(out_count), exp_count(h_m[2]));
      check(int'(out_bits) == exp_bits(h_m[2], h_re[2], h_im[2]), h_tag[2],
            int'(out_bits), exp_bits(h_m[2], h_re[2], h_im[2]));
    end else begin
      check(out_bits == 6'd0 && out_count == 3'd0, "R8 idle zero",
            int'({out_count, out_bits}), 0);
    end
    for (int i = 2; i > 0; i--) begin
      h_v[i] = h_v[i-1]; h_m[i] = h_m[i-1]; h_re[i] = h_re[i-1];
      h_im[i] = h_im[i-1]; h_tag[i] = h_tag[i-1];
    end
    h_v[0] = v; h_m[0] = m; h_re[0] = re; h_im[0] = im; h_tag[0] = tag;
    in_valid = v; in_mode = m; in_re = re; in_im = im;
  endtask

  function automatic string tag_for(input logic [1:0] m);
    case (m)
      2'd0: return "R2 bpsk";
      2'd1: return "R3 qpsk";
      2'd2: return "R4 R5 R6 16qam";
      default: return "R4 R5 R6 64qam";
    endcase
  endfunction

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 1'b0; h_m[i] = '0; h_re[i] = '0; h_im[i] = '0; h_tag[i] = "";
    end
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_bits == 6'd0 && out_count == 3'd0, "R8 reset",
          int'({out_valid, out_count, out_bits}), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 65536; k++) begin
      logic [15:0] re, im;
      re = 16'(k + 32768);
      im = 16'(k * 40503 + 12345);
      cycle((k % 97) != 5, 2'd3, re, im, tag_for(2'd3));
    end
    for (int md = 0; md < 3; md++) begin
      for (int k = 0; k < 65536; k += 4) begin
        logic [15:0] re, im;
        re = 16'(k + 32768 + md);
        im = 16'(k * 7919 + md * 1000);
        cycle(1'b1, 2'(md), re, im, tag_for(2'(md)));
      end
    end
    lfsr = 16'hACE1;
    for (int k = 0; k < 4096; k++) begin
      logic [15:0] re;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      re = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[3:0] != 4'd0, lfsr[5:4], re, lfsr, "R9 mixed modes");
    end
    for (int k = 0; k < 5; k++) cycle(1'b0, 2'd0, 16'h0, 16'h0, "R8");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule